// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block tracks coherence state for the lines of one processor's private cache on a shared snooping bus. Each line is Invalid, Shared, Exclusive or Modified. Processor loads and stores that the local copy cannot satisfy become bus transactions: a read, a read-for-ownership, an upgrade, or a writeback of a dirty victim. Transactions from the other bus masters are presented on a separate snoop port, and the block answers them in the same cycle.

The Exclusive state is what sets this controller apart from a three-state design. A read miss samples a wired-OR "shared" line in the cycle its data returns. If no other cache asserted that line, the copy is installed as Exclusive, and a later store to it turns it Modified with no bus traffic. While snooping a read to a line it holds, this controller drives its own contribution to the shared line.

A parameter decides whether an Exclusive holder also drives its data onto the bus for a snooped read, or leaves that to memory. The cache is direct-mapped. The address is split into an index (the low `INDEX_W` bits) and a tag (the remaining bits).

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: no snoop is answered, and `bus_req` and `cpu_done` are low.
- R2: A read miss requests the bus with command code 0 (read) at the request address. The line is filled as Exclusive if `bus_shared_in` is low in the response cycle, and as Shared if it is high. The response data is returned on `cpu_rdata`.
- R3: A store to an Exclusive line completes without any bus request and leaves the line Modified, holding the new data.
- R4: A load that hits a Shared, Exclusive or Modified line completes without a bus request and returns the stored data. `cpu_done` is a single-cycle pulse.
- R5: A store that hits a Shared line issues command code 2 (upgrade), completes at the grant with no data response, and leaves the line Modified.
- R6: A store miss issues command code 1 (read-exclusive), discards the response data, and installs the line as Modified with the store data.
- R7: A snooped read (code 0) to a held line asserts `snp_shared`. A Modified holder supplies its data on `snp_data` with `snp_supply` and moves to Shared. An Exclusive holder moves to Shared. A Shared holder stays Shared.
- R8: With `SUPPLY_FROM_E` set to 1, an Exclusive holder supplies its data for a snooped read. With 0, it asserts only `snp_shared` and leaves the data to memory.
- R9: A snooped read-exclusive (code 1) or upgrade (code 2) to a held line invalidates it without asserting `snp_shared`. Only a Modified holder supplies data, and only for code 1.
- R10: A miss whose index holds a Modified line with a different tag first writes the victim back with code 3, using the victim address and data, and then issues the fill request. Shared or Exclusive victims are dropped with no bus traffic.
- R11: A processor request is not accepted in any cycle in which `snp_valid` is high.
- R12: If the Shared copy behind a pending upgrade is invalidated by a snoop before the grant, the request is issued as read-exclusive (code 1) instead.
- R13: A snooped writeback (code 3), and any snoop to a tag not held, gets no response and changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| bus_req | output | 1 | Bus request, held until grant |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_gnt | input | 1 | Grant; the command transfers in this cycle |
| bus_resp_valid | input | 1 | Fill data valid for a read or read-exclusive |
| bus_resp_data | input | DATA_W | Fill data |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled with `bus_resp_valid` |
| snp_valid | input | 1 | Another master's transaction is visible |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache's contribution to the shared line |
| snp_supply | output | 1 | This cache drives `snp_data` |
| snp_data | output | DATA_W | Supplied line data |

## Verification
The processor side is driven with each hit and miss case against every starting state. Counting bus commands separates the silent Exclusive-to-Modified store from the upgrade taken from Shared. The same read miss is run with the shared line low and then high, and the two fills are told apart by the bus traffic of the store that follows. Snoops of every command code are applied to Invalid, Shared, Exclusive and Modified copies and to absent tags. Two instances, one per supply mode, receive identical stimulus so that the Exclusive-supply choice is the only difference observed. The writeback race, the upgrade-to-read-exclusive race and the snoop stall are each staged cycle by cycle.

// File: rtl/mesi_pkg.sv
// Shared types for the MESI snooping controller.
// Assumes: 2-bit encodings are visible on the bus ports.
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_RDX  = 2'd1,
        CMD_UPGR = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_t;
endpackage

// File: rtl/mesi_line_store.sv
// Direct-mapped array of coherence state, tag and data per line.
// Two read ports (request side, snoop side), two write ports.
// Assumes: the snoop write and the request write never target the same
// line in one cycle; if they do, the snoop state update wins.
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2,
    parameter int DATA_W  = 8,
    localparam int TAG_W  = ADDR_W - INDEX_W,
    localparam int LINES  = 1 << INDEX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] lk_idx,
    output line_st_t           lk_state,
    output logic [TAG_W-1:0]   lk_tag,
    output logic [DATA_W-1:0]  lk_data,
    input  logic [INDEX_W-1:0] sn_idx,
    output line_st_t           sn_state,
    output logic [TAG_W-1:0]   sn_tag,
    output logic [DATA_W-1:0]  sn_data,
    input  logic               fw_en,
    input  line_st_t           fw_state,
    input  logic [TAG_W-1:0]   fw_tag,
    input  logic [DATA_W-1:0]  fw_data,
    input  logic               sw_en,
    input  line_st_t           sw_state
);
    line_st_t          st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    // Coherence state: cleared on reset, snoop update applied last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
        end else begin
            if (fw_en) st_q[lk_idx] <= fw_state;
            if (sw_en) st_q[sn_idx] <= sw_state;
        end
    end

    // Tag and data payload: written only by the request side.
    always_ff @(posedge clk) begin
        if (fw_en) begin
            tag_q[lk_idx] <= fw_tag;
            dat_q[lk_idx] <= fw_data;
        end
    end

    // Asynchronous read ports.
    always_comb begin
        lk_state = st_q[lk_idx];
        lk_tag   = tag_q[lk_idx];
        lk_data  = dat_q[lk_idx];
        sn_state = st_q[sn_idx];
        sn_tag   = tag_q[sn_idx];
        sn_data  = dat_q[sn_idx];
    end
endmodule

// File: rtl/mesi_snoop_unit.sv
// Combinational response to another master's bus transaction: shared
// contribution, data supply and the next state of the snooped line.
// Assumes: the line fields come from the store read at the snoop index.
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TAG_W         = 6,
    parameter bit SUPPLY_FROM_E = 1'b1
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              shared_o,
    output logic              supply_o,
    output logic [DATA_W-1:0] data_o,
    output logic              upd_en,
    output line_st_t          upd_state
);
    logic held;

    // Decide the reply and the state change for a snooped command.
    always_comb begin
        held      = snp_valid && (line_state != ST_I) && (line_tag == snp_tag);
        shared_o  = 1'b0;
        supply_o  = 1'b0;
        upd_en    = 1'b0;
        upd_state = line_state;
        if (held) begin
            case (snp_cmd)
                CMD_RD: begin
                    shared_o = 1'b1;
                    if (line_state == ST_M) begin
                        supply_o  = 1'b1;
                        upd_en    = 1'b1;
                        upd_state = ST_S;
                    end else if (line_state == ST_E) begin
                        supply_o  = SUPPLY_FROM_E;
                        upd_en    = 1'b1;
                        upd_state = ST_S;
                    end
                end
                CMD_RDX, CMD_UPGR: begin
                    supply_o  = (line_state == ST_M) && (snp_cmd == CMD_RDX);
                    upd_en    = 1'b1;
                    upd_state = ST_I;
                end
                default: ;
            endcase
        end
        data_o = supply_o ? line_data : '0;
    end
endmodule

// File: rtl/mesi_req_fsm.sv
// Processor-side sequencer: serves hits locally, writes back dirty victims,
// issues read / read-exclusive / upgrade requests and installs fills.
// Assumes: no snoop is presented between our grant and our response, and
// cpu inputs are held stable until cpu_done.
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2,
    parameter int DATA_W  = 8,
    localparam int TAG_W  = ADDR_W - INDEX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_done,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               snp_valid,
    output logic               bus_req,
    output logic [1:0]         bus_cmd,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_gnt,
    input  logic               bus_resp_valid,
    input  logic [DATA_W-1:0]  bus_resp_data,
    input  logic               bus_shared_in,
    output logic [INDEX_W-1:0] lk_idx,
    input  line_st_t           lk_state,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [DATA_W-1:0]  lk_data,
    output logic               fw_en,
    output line_st_t           fw_state,
    output logic [TAG_W-1:0]   fw_tag,
    output logic [DATA_W-1:0]  fw_data
);
    typedef enum logic [2:0] {F_IDLE, F_WB, F_REQ, F_WAIT, F_DONE} fsm_t;

    fsm_t              st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
    bus_cmd_t          cmd_q, req_cmd;
    logic [TAG_W-1:0]  cur_tag;
    logic              hit, accept;

    // Lookup address: live request while idle, latched request otherwise.
    always_comb begin
        cur_tag = (st_q == F_IDLE) ? cpu_addr[ADDR_W-1:INDEX_W] : addr_q[ADDR_W-1:INDEX_W];
        lk_idx  = (st_q == F_IDLE) ? cpu_addr[INDEX_W-1:0] : addr_q[INDEX_W-1:0];
        hit     = (lk_state != ST_I) && (lk_tag == cur_tag);
        accept  = (st_q == F_IDLE) && cpu_req && !snp_valid;
        if (!we_q)                       req_cmd = CMD_RD;
        else if (hit && lk_state == ST_S) req_cmd = CMD_UPGR;
        else                              req_cmd = CMD_RDX;
    end

    // Next state, bus drive and line write for each sequencer state.
    always_comb begin
        st_d      = st_q;
        bus_req   = 1'b0;
        bus_cmd   = req_cmd;
        bus_addr  = addr_q;
        bus_wdata = '0;
        fw_en     = 1'b0;
        fw_state  = lk_state;
        fw_tag    = lk_tag;
        fw_data   = lk_data;
        rdata_d   = rdata_q;
        case (st_q)
            F_IDLE: begin
                if (accept) begin
                    if (hit) begin
                        if (!cpu_we) begin
                            rdata_d = lk_data;
                            st_d    = F_DONE;
                        end else if (lk_state == ST_S) begin
                            st_d = F_REQ;
                        end else begin
                            fw_en    = 1'b1;
                            fw_state = ST_M;
                            fw_data  = cpu_wdata;
                            st_d     = F_DONE;
                        end
                    end else begin
                        st_d = (lk_state == ST_M) ? F_WB : F_REQ;
                    end
                end
            end
            F_WB: begin
                bus_cmd   = CMD_WB;
                bus_addr  = {lk_tag, addr_q[INDEX_W-1:0]};
                bus_wdata = lk_data;
                if (lk_state != ST_M) begin
                    st_d = F_REQ;
                end else begin
                    bus_req = 1'b1;
                    if (bus_gnt) begin
                        fw_en    = 1'b1;
                        fw_state = ST_I;
                        st_d     = F_REQ;
                    end
                end
            end
            F_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    if (req_cmd == CMD_UPGR) begin
                        fw_en    = 1'b1;
                        fw_state = ST_M;
                        fw_tag   = addr_q[ADDR_W-1:INDEX_W];
                        fw_data  = wdata_q;
                        st_d     = F_DONE;
                    end else begin
                        st_d = F_WAIT;
                    end
                end
            end
            F_WAIT: begin
                if (bus_resp_valid) begin
                    fw_en  = 1'b1;
                    fw_tag = addr_q[ADDR_W-1:INDEX_W];
                    if (cmd_q == CMD_RD) begin
                        fw_state = bus_shared_in ? ST_S : ST_E;
                        fw_data  = bus_resp_data;
                        rdata_d  = bus_resp_data;
                    end else begin
                        fw_state = ST_M;
                        fw_data  = wdata_q;
                    end
                    st_d = F_DONE;
                end
            end
            default: st_d = F_IDLE;
        endcase
    end

    // Sequencer state and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= F_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            cmd_q   <= CMD_RD;
        end else begin
            st_q    <= st_d;
            rdata_q <= rdata_d;
            if (accept) begin
                addr_q  <= cpu_addr;
                we_q    <= cpu_we;
                wdata_q <= cpu_wdata;
            end
            if (st_q == F_REQ && bus_gnt) cmd_q <= req_cmd;
        end
    end

    assign cpu_done  = (st_q == F_DONE);
    assign cpu_rdata = rdata_q;

    // R3: store to an Exclusive line finishes next cycle with the line Modified
    p_silent_e_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_we && hit && lk_state == ST_E) |=> (st_q == F_DONE && lk_state == ST_M));

    // R5: an upgrade grant leaves the line Modified and completes
    p_upgr_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == F_REQ && bus_gnt && bus_cmd == CMD_UPGR) |=> (lk_state == ST_M && cpu_done));

    // R2: read fill state follows the shared line of the response cycle
    p_fill_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == F_WAIT && bus_resp_valid && cmd_q == CMD_RD) |=>
            (lk_state == ($past(bus_shared_in) ? ST_S : ST_E)));

    // R10: a granted writeback invalidates the victim before the fill request
    p_wb_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == F_WB && bus_req && bus_gnt) |=> (st_q == F_REQ && lk_state == ST_I));

    // R11: no request is accepted while a snoop is presented
    p_snoop_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == F_IDLE && snp_valid) |=> (st_q == F_IDLE));

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
// Top of the MESI snooping controller: line store, snoop responder and
// processor-side sequencer.
// Assumes: the bus arbiter serialises transactions and shows no foreign
// snoop between this controller's grant and its fill response.
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int INDEX_W       = 2,
    parameter int DATA_W        = 8,
    parameter bit SUPPLY_FROM_E = 1'b1,
    localparam int TAG_W        = ADDR_W - INDEX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_resp_valid,
    input  logic [DATA_W-1:0] bus_resp_data,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);
    logic [INDEX_W-1:0] lk_idx;
    line_st_t           lk_state, sn_state, fw_state, sw_state;
    logic [TAG_W-1:0]   lk_tag, sn_tag, fw_tag;
    logic [DATA_W-1:0]  lk_data, sn_data, fw_data;
    logic               fw_en, sw_en;

    mesi_line_store #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_state(lk_state), .lk_tag(lk_tag), .lk_data(lk_data),
        .sn_idx(snp_addr[INDEX_W-1:0]), .sn_state(sn_state), .sn_tag(sn_tag), .sn_data(sn_data),
        .fw_en(fw_en), .fw_state(fw_state), .fw_tag(fw_tag), .fw_data(fw_data),
        .sw_en(sw_en), .sw_state(sw_state)
    );

    mesi_snoop_unit #(.DATA_W(DATA_W), .TAG_W(TAG_W), .SUPPLY_FROM_E(SUPPLY_FROM_E)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:INDEX_W]),
        .line_state(sn_state), .line_tag(sn_tag), .line_data(sn_data),
        .shared_o(snp_shared), .supply_o(snp_supply), .data_o(snp_data),
        .upd_en(sw_en), .upd_state(sw_state)
    );

    mesi_req_fsm #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .snp_valid(snp_valid),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_resp_valid(bus_resp_valid), .bus_resp_data(bus_resp_data),
        .bus_shared_in(bus_shared_in),
        .lk_idx(lk_idx), .lk_state(lk_state), .lk_tag(lk_tag), .lk_data(lk_data),
        .fw_en(fw_en), .fw_state(fw_state), .fw_tag(fw_tag), .fw_data(fw_data)
    );

    // R9: a snooped read-exclusive or upgrade hit leaves the snooped line Invalid
    p_snoop_inval_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_cmd == CMD_RDX || snp_cmd == CMD_UPGR) && sn_state != ST_I
         && sn_tag == snp_addr[ADDR_W-1:INDEX_W] && !fw_en) |=> (sn_state == ST_I || !$stable(snp_addr)));

    // R7: a snooped read never leaves a held line Exclusive or Modified
    p_snoop_demote_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == CMD_RD && snp_shared && !fw_en) |=>
            (!$stable(snp_addr) || sn_state == ST_S));
endmodule

// File: tb/mesi_snoop_ctrl_test.sv
// Self-checking bench: two instances (data supply from E on and off)
// receive identical stimulus; a task plays the bus arbiter and memory.
module mesi_snoop_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 0, cpu_we = 0;
    logic [7:0] cpu_addr = 0, cpu_wdata = 0;
    logic       bus_gnt = 0, bus_resp_valid = 0, bus_shared_in = 0;
    logic [7:0] bus_resp_data = 0;
    logic       snp_valid = 0;
    logic [1:0] snp_cmd = 0;
    logic [7:0] snp_addr = 0;

    logic       cpu_done, bus_req, snp_shared, snp_supply;
    logic [7:0] cpu_rdata, bus_addr, bus_wdata, snp_data;
    logic [1:0] bus_cmd;
    logic       m_done, m_breq, m_shared, m_supply;
    logic [7:0] m_rdata, m_baddr, m_bwdata, m_sdata;
    logic [1:0] m_bcmd;

    int checks = 0, errors = 0;
    int ncmd, op_rdata;
    int cmd_log [4];
    int adr_log [4];
    int wd_log  [4];
    int s_sh, s_sup, s_dat, s_sup2;
    bit finished = 0;

    always #4 clk = ~clk;

    mesi_snoop_ctrl #(.SUPPLY_FROM_E(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_resp_valid(bus_resp_valid), .bus_resp_data(bus_resp_data),
        .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
        .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data));

    mesi_snoop_ctrl #(.SUPPLY_FROM_E(1'b0)) uut_mem (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_done(m_done), .cpu_rdata(m_rdata),
        .bus_req(m_breq), .bus_cmd(m_bcmd), .bus_addr(m_baddr), .bus_wdata(m_bwdata),
        .bus_gnt(bus_gnt), .bus_resp_valid(bus_resp_valid), .bus_resp_data(bus_resp_data),
        .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
        .snp_addr(snp_addr), .snp_shared(m_shared), .snp_supply(m_supply), .snp_data(m_sdata));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Run one processor request, acting as arbiter and memory.
    task automatic do_op(input bit we, input int a, input int wd, input bit shr, input int rdat);
        bit pend = 0;
        bit fin  = 0;
        ncmd = 0;
        cpu_req = 1; cpu_we = we; cpu_addr = a[7:0]; cpu_wdata = wd[7:0];
        for (int c = 0; c < 40 && !fin; c++) begin
            @(negedge clk);
            bus_gnt = 0; bus_resp_valid = 0; bus_shared_in = 0; bus_resp_data = 0;
            if (cpu_done) begin
                fin = 1; op_rdata = int'(cpu_rdata); cpu_req = 0;
            end else if (pend) begin
                bus_resp_valid = 1; bus_resp_data = rdat[7:0]; bus_shared_in = shr; pend = 0;
            end else if (bus_req) begin
                if (ncmd < 4) begin
                    cmd_log[ncmd] = int'(bus_cmd);
                    adr_log[ncmd] = int'(bus_addr);
                    wd_log[ncmd]  = int'(bus_wdata);
                end
                ncmd++;
                bus_gnt = 1;
                if (bus_cmd == 2'd0 || bus_cmd == 2'd1) pend = 1;
            end
        end
        if (!fin) begin
            cpu_req = 0;
            chk("op completes", 0, 1);
        end
    endtask

    // Present one snoop for a cycle and capture both instances' replies.
    task automatic snoop(input int cmd, input int a);
        snp_valid = 1; snp_cmd = cmd[1:0]; snp_addr = a[7:0];
        #1;
        s_sh = int'(snp_shared); s_sup = int'(snp_supply); s_dat = int'(snp_data);
        s_sup2 = int'(m_supply);
        @(negedge clk);
        snp_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state, swept over every index
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 cpu_done", int'(cpu_done), 0);
        for (int i = 0; i < 4; i++) begin
            snoop(0, i);
            chk("R1 no shared", s_sh, 0);
            chk("R1 no supply", s_sup, 0);
        end

        // R2: read miss, shared low -> Exclusive
        do_op(0, 'h10, 0, 0, 'hA1);
        chk("R2 one cmd", ncmd, 1);
        chk("R2 cmd RD", cmd_log[0], 0);
        chk("R2 addr", adr_log[0], 'h10);
        chk("R2 rdata", op_rdata, 'hA1);
        // R8 / R7: snooped read on Exclusive
        snoop(0, 'h10);
        chk("R7 E shared", s_sh, 1);
        chk("R8 E supplies (mode 1)", s_sup, 1);
        chk("R8 E data", s_dat, 'hA1);
        chk("R8 E no supply (mode 0)", s_sup2, 0);
        // R4: read hit in Shared
        do_op(0, 'h10, 0, 0, 'hFF);
        chk("R4 S hit no bus", ncmd, 0);
        chk("R4 S hit data", op_rdata, 'hA1);

        // R3: silent E->M
        do_op(0, 'h21, 0, 0, 'hB2);
        do_op(1, 'h21, 'hC3, 0, 0);
        chk("R3 no bus", ncmd, 0);
        do_op(0, 'h21, 0, 0, 'hFF);
        chk("R4 M hit data", op_rdata, 'hC3);
        chk("R4 M hit no bus", ncmd, 0);
        snoop(0, 'h21);
        chk("R7 M shared", s_sh, 1);
        chk("R7 M flush", s_sup, 1);
        chk("R7 M data", s_dat, 'hC3);
        chk("R7 M flush mode 0", s_sup2, 1);
        // R5: store on Shared -> upgrade
        do_op(1, 'h21, 'hD4, 0, 0);
        chk("R5 one cmd", ncmd, 1);
        chk("R5 cmd UPGR", cmd_log[0], 2);
        chk("R5 addr", adr_log[0], 'h21);
        do_op(0, 'h21, 0, 0, 'hFF);
        chk("R5 M data", op_rdata, 'hD4);
        chk("R5 M no bus", ncmd, 0);

        // R6: store miss
        do_op(1, 'h32, 'hE5, 0, 'h00);
        chk("R6 cmd RDX", cmd_log[0], 1);
        chk("R6 one cmd", ncmd, 1);
        snoop(1, 'h32);
        chk("R9 RDX on M supply", s_sup, 1);
        chk("R6 stored data", s_dat, 'hE5);
        chk("R9 RDX no shared", s_sh, 0);
        // R9: line now invalid -> read misses; shared high -> Shared
        do_op(0, 'h32, 0, 1, 'h5A);
        chk("R9 miss after RDX", ncmd, 1);
        chk("R2 rdata shared fill", op_rdata, 'h5A);
        snoop(2, 'h32);
        chk("R9 UPGR no supply", s_sup, 0);
        chk("R9 UPGR no shared", s_sh, 0);
        do_op(0, 'h32, 0, 0, 'h6B);
        chk("R9 miss after UPGR", ncmd, 1);
        do_op(1, 'h32, 'h11, 0, 0);
        chk("R2 E fill store silent", ncmd, 0);
        do_op(0, 'h32, 0, 0, 'h6C);
        chk("R4 no bus on M", ncmd, 0);
        // R2 Shared fill: upgrade needed afterwards
        do_op(0, 'h13, 0, 1, 'h44);
        do_op(1, 'h13, 'h45, 0, 0);
        chk("R2 S fill needs UPGR", cmd_log[0], 2);

        // R10: dirty victim (0x21 holds D4 as M)
        do_op(0, 'h61, 0, 0, 'h66);
        chk("R10 two cmds", ncmd, 2);
        chk("R10 WB first", cmd_log[0], 3);
        chk("R10 WB addr", adr_log[0], 'h21);
        chk("R10 WB data", wd_log[0], 'hD4);
        chk("R10 then RD", cmd_log[1], 0);
        chk("R10 RD addr", adr_log[1], 'h61);
        chk("R10 rdata", op_rdata, 'h66);
        do_op(0, 'hA1, 0, 0, 'h77);
        chk("R10 clean victim silent", ncmd, 1);
        chk("R10 clean victim RD", cmd_log[0], 0);

        // R13: snooped writeback and absent tag are ignored
        snoop(3, 'hA1);
        chk("R13 WB no shared", s_sh, 0);
        chk("R13 WB no supply", s_sup, 0);
        snoop(0, 'hE1);
        chk("R13 absent tag", s_sh, 0);
        do_op(1, 'hA1, 'h12, 0, 0);
        chk("R13 line still E", ncmd, 0);
        snoop(0, 'hA1);
        chk("R13 M data", s_dat, 'h12);

        // R11: snoop stalls acceptance
        do_op(0, 'h03, 0, 0, 'h77);
        cpu_req = 1; cpu_we = 0; cpu_addr = 'h03;
        snp_valid = 1; snp_cmd = 0; snp_addr = 'h80;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R11 stalled", int'(cpu_done), 0);
        end
        snp_valid = 0;
        @(negedge clk);
        chk("R11 done after snoop", int'(cpu_done), 1);
        chk("R11 data", int'(cpu_rdata), 'h77);
        cpu_req = 0;

        // R12: upgrade turned into read-exclusive
        snoop(0, 'h03);
        cpu_req = 1; cpu_we = 1; cpu_addr = 'h03; cpu_wdata = 'h99;
        @(negedge clk);
        chk("R12 upgrade pending", int'(bus_req && bus_cmd == 2'd2), 1);
        snp_valid = 1; snp_cmd = 1; snp_addr = 'h03;
        #1;
        chk("R12 S no supply", int'(snp_supply), 0);
        @(negedge clk);
        snp_valid = 0;
        chk("R12 now RDX", int'(bus_req && bus_cmd == 2'd1), 1);
        do_op(1, 'h03, 'h99, 0, 'h00);
        chk("R12 one cmd", ncmd, 1);
        chk("R12 cmd RDX", cmd_log[0], 1);
        snoop(0, 'h03);
        chk("R12 M supply", s_sup, 1);
        chk("R12 M data", s_dat, 'h99);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule